// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the slave end of a three-wire serial link: an enable line, a serial clock and one bidirectional data line. The data line is presented as a separate input, output and output enable. A host raises the enable line and shifts in a command byte. The command selects one of two target spaces (clock registers or a 31-byte scratch RAM), an address and a direction. The block then moves data bytes in or out, least significant bit first. Any transfer can be a single byte or a burst.

The enable, clock and data inputs are brought into the system clock domain by a synchronizer. Edges of the serial clock are found by comparing successive synchronized samples. Storage sits outside the block, behind a parallel read port and a parallel write port. The read port is an address paired with a combinational data return. The write port is a one-cycle strobe with address and data.

The block holds only the write-protect bit, which sits at the top of the clock burst range. It stages clock burst writes so that a partial burst changes nothing.

Top module: `serial_reg_slave`

## Requirements
- R1: After reset the data output enable is low, no write strobe is issued, and write protect is 1, so a read of clock address 7 returns 0x80.
- R2: The command byte and the data bytes move LSB first, and input bits are sampled on rising serial clock edges. Command bit 0 is 1 for a read and 0 for a write. Bits 5:1 are the address. Bit 6 is 1 for RAM and 0 for the clock space.
- R3: In a read, the output enable stays low until the first falling edge after the eighth command bit, and the first data bit is driven on that edge. A later bit is driven on each later falling edge. The enable is released on every rising edge, and within a few system cycles of the enable line dropping.
- R4: A single-byte write issues exactly one write strobe after the eighth data bit. Further serial clocks before the enable line drops have no effect.
- R5: A single-byte read sends the same byte again for every further group of eight clocks while the enable line stays high.
- R6: A command whose bit 7 is 0 causes no write.
- R7: While write protect is 1, every write is discarded except a write to clock address 7. A read of clock address 7 returns write protect in bit 7 and 0 in bits 6:0, whatever was written to those bits.
- R8: Clock addresses 9 to 30 hold no storage: writes to them produce no strobe and reads from them return 0.
- R9: Address 31 in RAM space starts a burst at address 0. Each complete byte is written as it arrives, even if the burst stops early, and bytes after the 31st are ignored.
- R10: Address 31 in clock space starts a burst over clock addresses 0 to 7. Nothing is written unless all eight bytes arrive, and nothing is written if write protect was 1 when the burst began. The eighth byte's bit 7 becomes the new write protect.
- R11: A burst read starts at address 0 and returns to address 0 after the last address (7 for clock space, 30 for RAM) while clocks continue.
- R12: Dropping the enable line in the middle of a data byte abandons that byte without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Serial enable line; high frames a transfer |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, output value |
| sdio_oe_o | output | 1 | Serial data line output enable |
| rd_ram_o | output | 1 | Read port space: 1 RAM, 0 clock registers |
| rd_addr_o | output | 5 | Read port address |
| rd_data_i | input | 8 | Read data for rd_ram_o/rd_addr_o, combinational |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_ram_o | output | 1 | Write space: 1 RAM, 0 clock registers |
| wr_addr_o | output | 5 | Write address |
| wr_data_o | output | 8 | Write data |

## Verification
The bench builds the block with its defaults: eight registers in the clock burst, nine clock addresses with storage, 31 RAM bytes and a two-stage synchronizer. With these sizes the bench can reach several boundaries. A full RAM burst reaches its last byte, one ignored extra byte and the wrap back to 0. The clock burst ends on the write-protect slot, and address 8 has storage but lies outside the burst. Each serial half period is eight system cycles, so the synchronizer delay stays well inside each bit and the output enable can be sampled on both sides of every serial edge.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] BURST_ADDR = '1;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

  typedef struct packed {
    logic              enable;
    logic              ram;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } cmd_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES+1];

  assign chain[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s+1] <= '0;
      else         chain[s+1] <= chain[s];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/srs_burst_stage.sv
module srs_burst_stage #(
  parameter int unsigned N_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       allow_i,
  input  logic                       push_i,
  input  logic [7:0]                 data_i,
  output logic                       act_o,
  output logic [$clog2(N_REGS)-1:0]  idx_o,
  output logic [7:0]                 data_o
);
  localparam int unsigned IW = $clog2(N_REGS);
  localparam int unsigned CW = $clog2(N_REGS + 1);

  logic [7:0]    buf_q [N_REGS];
  logic [CW-1:0] cnt_q;
  logic          allow_q;
  logic          act_q;
  logic [IW-1:0] idx_q;
  logic          fill;

  assign fill = push_i && (cnt_q < CW'(N_REGS));

  always_ff @(posedge clk_i) begin
    if (fill) buf_q[cnt_q[IW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      allow_q <= 1'b0;
      act_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (act_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(N_REGS - 1)) act_q <= 1'b0;
      end
      if (clear_i) begin
        cnt_q   <= '0;
        allow_q <= allow_i;
      end else if (fill) begin
        cnt_q <= cnt_q + 1'b1;
        // commit only once the last slot is filled
        if (cnt_q == CW'(N_REGS - 1) && allow_q) begin
          act_q <= 1'b1;
          idx_q <= '0;
        end
      end
    end
  end

  assign act_o  = act_q;
  assign idx_o  = idx_q;
  assign data_o = buf_q[idx_q];

  assert_commit_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> ($past(cnt_q) == CW'(N_REGS - 1)));
  assert_commit_allowed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> allow_q);
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLK_REGS    = 8,
  parameter int unsigned CLK_STORE   = 9,
  parameter int unsigned RAM_BYTES   = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              rd_ram_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_en_o,
  output logic              wr_ram_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam int unsigned IW = $clog2(CLK_REGS);
  localparam logic [ADDR_W-1:0] WP_ADDR  = ADDR_W'(CLK_REGS - 1);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_REGS - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_BYTES - 1);

  function automatic logic has_store(input logic ram, input logic [ADDR_W-1:0] a);
    return ram ? (int'(a) < int'(RAM_BYTES)) : (int'(a) < int'(CLK_STORE));
  endfunction

  // input synchronization and edge detection
  logic [2:0] sync_q;
  logic       ce_s, sclk_s, sdi_s, sclk_d_q, rise, fall;

  srs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_i, sclk_i, sdio_i}),
    .q_o   (sync_q)
  );

  assign ce_s   = sync_q[2];
  assign sclk_s = sync_q[1];
  assign sdi_s  = sync_q[0];
  assign rise   = ce_s && sclk_s && !sclk_d_q;
  assign fall   = ce_s && !sclk_s && sclk_d_q;

  // transfer state
  phase_e            phase_q;
  logic [2:0]        bit_q;
  logic [7:0]        cmd_sh_q, din_q, obyte_q;
  cmd_t              cmd_q, cmd_next;
  logic              burst_q, done_q, sdo_q, oe_q, wp_q;
  logic [ADDR_W-1:0] idx_q, idx_adv, last_idx;
  logic [7:0]        din_next, rd_byte, cur_byte;

  assign cmd_next = cmd_t'({sdi_s, cmd_sh_q[7:1]});
  assign din_next = {sdi_s, din_q[7:1]};
  assign last_idx = cmd_q.ram ? RAM_LAST : CLK_LAST;
  assign idx_adv  = !burst_q ? idx_q : ((idx_q == last_idx) ? '0 : idx_q + 1'b1);

  always_comb begin
    if (!has_store(cmd_q.ram, idx_q))            rd_byte = '0;
    else if (!cmd_q.ram && idx_q == WP_ADDR)     rd_byte = {wp_q, 7'd0};
    else                                         rd_byte = rd_data_i;
  end
  assign cur_byte = (bit_q == 3'd0) ? rd_byte : obyte_q;

  // write decisions
  logic byte_done, ctrl_hit, dir_fire, wp_wr_dir, push, cmd_end;

  assign cmd_end   = rise && phase_q == PH_CMD && bit_q == 3'd7;
  assign byte_done = rise && phase_q == PH_WR && bit_q == 3'd7 && !done_q;
  assign ctrl_hit  = !cmd_q.ram && idx_q == WP_ADDR;
  assign dir_fire  = byte_done && cmd_q.enable && has_store(cmd_q.ram, idx_q) && !ctrl_hit
                     && !wp_q && (cmd_q.ram || !burst_q);
  assign wp_wr_dir = byte_done && !burst_q && ctrl_hit && cmd_q.enable;
  assign push      = byte_done && burst_q && !cmd_q.ram;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      phase_q  <= PH_CMD;
      bit_q    <= '0;
      cmd_sh_q <= '0;
      cmd_q    <= '0;
      burst_q  <= 1'b0;
      idx_q    <= '0;
      din_q    <= '0;
      done_q   <= 1'b0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      obyte_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      if (!ce_s) begin
        phase_q <= PH_CMD;
        bit_q   <= '0;
        oe_q    <= 1'b0;
        done_q  <= 1'b0;
      end else if (rise) begin
        oe_q  <= 1'b0;
        bit_q <= bit_q + 3'd1;
        unique case (phase_q)
          PH_CMD: begin
            cmd_sh_q <= cmd_next;
            if (bit_q == 3'd7) begin
              cmd_q   <= cmd_next;
              burst_q <= (cmd_next.addr == BURST_ADDR);
              idx_q   <= (cmd_next.addr == BURST_ADDR) ? '0 : cmd_next.addr;
              phase_q <= cmd_next.rd ? PH_RD : PH_WR;
              done_q  <= 1'b0;
            end
          end
          PH_WR: begin
            din_q <= din_next;
            if (byte_done) begin
              if (!burst_q) done_q <= 1'b1;
              else begin
                idx_q  <= idx_adv;
                done_q <= (idx_q == last_idx);
              end
            end
          end
          PH_RD: if (bit_q == 3'd7) idx_q <= idx_adv;
          default: ;
        endcase
      end else if (fall && phase_q == PH_RD) begin
        oe_q  <= 1'b1;
        sdo_q <= cur_byte[bit_q];
        if (bit_q == 3'd0) obyte_q <= rd_byte;
      end
    end
  end

  // clock burst staging
  logic          c_act;
  logic [IW-1:0] c_idx;
  logic [7:0]    c_data;
  logic [ADDR_W-1:0] c_addr;

  srs_burst_stage #(.N_REGS(CLK_REGS)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(cmd_end),
    .allow_i(cmd_next.enable && !wp_q),
    .push_i (push),
    .data_i (din_next),
    .act_o  (c_act),
    .idx_o  (c_idx),
    .data_o (c_data)
  );
  assign c_addr = ADDR_W'(c_idx);

  // write port and write-protect bit
  logic              wr_en_q, wr_ram_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_ram_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wp_q      <= 1'b1;
    end else begin
      wr_en_q <= 1'b0;
      if (c_act) begin
        if (c_addr == WP_ADDR) wp_q <= c_data[7];
        else begin
          wr_en_q   <= 1'b1;
          wr_ram_q  <= 1'b0;
          wr_addr_q <= c_addr;
          wr_data_q <= c_data;
        end
      end else if (dir_fire) begin
        wr_en_q   <= 1'b1;
        wr_ram_q  <= cmd_q.ram;
        wr_addr_q <= idx_q;
        wr_data_q <= din_next;
      end
      if (wp_wr_dir) wp_q <= din_next[7];
    end
  end

  assign sdio_o    = sdo_q;
  assign sdio_oe_o = oe_q;
  assign rd_ram_o  = cmd_q.ram;
  assign rd_addr_o = idx_q;
  assign wr_en_o   = wr_en_q;
  assign wr_ram_o  = wr_ram_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  assert_release_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !sdio_oe_o);
  assert_release_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_s |=> !sdio_oe_o);
  assert_oe_read_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> phase_q == PH_RD);
  assert_wp_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !$past(wp_q));
  assert_wr_addr_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_ram_o ? (int'(wr_addr_o) < int'(RAM_BYTES))
                          : (int'(wr_addr_o) < int'(CLK_STORE) && wr_addr_o != WP_ADDR)));
endmodule

// File: tb/serial_reg_slave_tb_top.sv
module serial_reg_slave_tb_top;
  localparam int HALF = 8;
  localparam int NV   = 16;
  // {cmd, data, expected, requirement number}
  localparam logic [31:0] VECS [NV] = '{
    32'h82_12_00_02, 32'h83_00_12_02,   // R2 clock addr 1
    32'hC0_A5_00_02, 32'hC1_00_A5_02,   // R2 RAM addr 0
    32'hFC_3C_00_02, 32'hFD_00_3C_02,   // R2 RAM addr 30
    32'h90_5A_00_02, 32'h91_00_5A_02,   // R2 clock addr 8
    32'h92_FF_00_08, 32'h93_00_00_08,   // R8 empty clock addr 9
    32'hBC_FF_00_08, 32'hBD_00_00_08,   // R8 empty clock addr 30
    32'h02_99_00_06, 32'h83_00_12_06,   // R6 bit 7 clear, clock
    32'h40_11_00_06, 32'hC1_00_A5_06    // R6 bit 7 clear, RAM
  };

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, rd_ram, wr_en, wr_ram;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] clk_mem [9];
  logic [7:0] ram_mem [31];
  int wr_cnt = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(sdo_oe), .rd_ram_o(rd_ram), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_ram_o(wr_ram), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  always_comb begin
    if (rd_ram) rd_data = (rd_addr < 5'd31) ? ram_mem[rd_addr] : 8'h00;
    else        rd_data = (rd_addr < 5'd9)  ? clk_mem[rd_addr] : 8'h00;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++)  clk_mem[i] <= 8'h00;
      for (int i = 0; i < 31; i++) ram_mem[i] <= 8'h00;
    end else if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (wr_ram) ram_mem[wr_addr] <= wr_data;
      else        clk_mem[wr_addr] <= wr_data;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_xfer();
    sclk = 1'b0; ce = 1'b1; wait_clk(HALF);
  endtask

  task automatic end_xfer();
    sclk = 1'b0; wait_clk(HALF); ce = 1'b0; wait_clk(2 * HALF);
  endtask

  task automatic send_bit(logic b);
    sclk = 1'b0; sdi = b; wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] b, inout logic oe_ok);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; wait_clk(HALF);
      b[i] = sdo; oe_ok &= sdo_oe;
      sclk = 1'b1; wait_clk(HALF);
      oe_ok &= !sdo_oe;
    end
  endtask

  task automatic wr1(logic [7:0] cmd, logic [7:0] d);
    start_xfer(); send_byte(cmd); send_byte(d); end_xfer();
  endtask

  task automatic rd1(logic [7:0] cmd, output logic [7:0] d);
    logic ok = 1'b1;
    start_xfer(); send_byte(cmd); recv_byte(d, ok); end_xfer();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic ok;
    int base;
    wait_clk(5);
    // R1 reset state
    check("R1 oe at reset", sdo_oe, 0);
    check("R1 strobe at reset", wr_en, 0);
    rst_n = 1'b1; wait_clk(5);
    rd1(8'h8F, d); check("R1 wp reset read", d, 8'h80);

    // R7 protection
    base = wr_cnt;
    wr1(8'h80, 8'h55); rd1(8'h81, d);
    check("R7 blocked write data", d, 8'h00);
    check("R7 blocked write strobes", wr_cnt - base, 0);
    wr1(8'h8E, 8'h7F); rd1(8'h8F, d);
    check("R7 wp clear, low bits read 0", d, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd, dat, exp;
      cmd = VECS[v][31:24]; dat = VECS[v][23:16]; exp = VECS[v][15:8];
      if (cmd[0]) begin
        rd1(cmd, d); n_chk++;
        if (d !== exp) begin
          n_fail++;
          $display("FAIL R%0d vector %0d act=%0h exp=%0h", VECS[v][7:0], v, d, exp);
        end
      end else wr1(cmd, dat);
    end

    // R3 output timing and release
    start_xfer(); send_byte(8'h83);
    check("R3 oe low before first fall", sdo_oe, 0);
    sclk = 1'b0; wait_clk(HALF);
    check("R3 oe high after first fall", sdo_oe, 1);
    check("R3 first bit", sdo, 0);
    sclk = 1'b1; wait_clk(HALF);
    check("R3 oe released on rise", sdo_oe, 0);
    sclk = 1'b0; wait_clk(HALF);
    check("R3 second bit", sdo, 1);
    ce = 1'b0; wait_clk(6);
    check("R3 oe released on ce low", sdo_oe, 0);
    wait_clk(2 * HALF);

    // R5 retransmit
    ok = 1'b1;
    start_xfer(); send_byte(8'h83);
    for (int k = 0; k < 3; k++) begin
      recv_byte(d, ok);
      check("R5 retransmitted byte", d, 8'h12);
    end
    end_xfer();
    check("R3 oe only between fall and rise", ok, 1);

    // R4 extra clocks ignored
    base = wr_cnt;
    start_xfer(); send_byte(8'h84); send_byte(8'h34); send_byte(8'hFF); end_xfer();
    check("R4 single strobe", wr_cnt - base, 1);
    rd1(8'h85, d); check("R4 data kept", d, 8'h34);

    // R12 abandoned byte
    base = wr_cnt;
    start_xfer(); send_byte(8'h86);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    end_xfer();
    check("R12 no strobe", wr_cnt - base, 0);
    rd1(8'h87, d); check("R12 data unchanged", d, 8'h00);

    // R9 partial RAM burst
    base = wr_cnt;
    start_xfer(); send_byte(8'hFE);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    end_xfer();
    check("R9 partial strobes", wr_cnt - base, 3);
    rd1(8'hC1, d); check("R9 byte 0", d, 8'h11);
    rd1(8'hC5, d); check("R9 byte 2", d, 8'h33);
    rd1(8'hC7, d); check("R9 byte 3 untouched", d, 8'h00);

    // R9 full RAM burst with one extra byte, R11 wrap on read
    base = wr_cnt;
    start_xfer(); send_byte(8'hFE);
    for (int k = 0; k < 32; k++) send_byte(8'(k * 3 + 1));
    end_xfer();
    check("R9 full burst strobes", wr_cnt - base, 31);
    ok = 1'b1;
    start_xfer(); send_byte(8'hFF);
    for (int k = 0; k < 33; k++) begin
      recv_byte(d, ok);
      check("R11 RAM burst read", d, 8'((k % 31) * 3 + 1));
    end
    end_xfer();

    // R10 partial clock burst
    base = wr_cnt;
    start_xfer(); send_byte(8'hBE);
    for (int k = 0; k < 5; k++) send_byte(8'hEE);
    end_xfer();
    check("R10 partial burst strobes", wr_cnt - base, 0);
    rd1(8'h83, d); check("R10 partial burst data", d, 8'h12);

    // R10 burst while protected
    wr1(8'h8E, 8'h80);
    base = wr_cnt;
    start_xfer(); send_byte(8'hBE);
    for (int k = 0; k < 8; k++) send_byte((k == 7) ? 8'h00 : 8'(8'h40 + k));
    end_xfer();
    check("R10 protected burst strobes", wr_cnt - base, 0);
    rd1(8'h8F, d); check("R10 wp kept", d, 8'h80);
    wr1(8'h8E, 8'h00);

    // R10 full clock burst, R11 wrap on read
    base = wr_cnt;
    start_xfer(); send_byte(8'hBE);
    for (int k = 0; k < 8; k++) send_byte((k == 7) ? 8'h00 : 8'(8'h20 + k));
    end_xfer();
    check("R10 full burst strobes", wr_cnt - base, 7);
    ok = 1'b1;
    start_xfer(); send_byte(8'hBF);
    for (int k = 0; k < 9; k++) begin
      recv_byte(d, ok);
      check("R11 clock burst read", d, (k == 7) ? 8'h00 : 8'(8'h20 + (k % 8)));
    end
    end_xfer();
    rd1(8'h91, d); check("R10 addr 8 outside burst", d, 8'h5A);

    // R10 eighth byte sets wp, R7 then blocks
    start_xfer(); send_byte(8'hBE);
    for (int k = 0; k < 8; k++) send_byte((k == 7) ? 8'h80 : 8'(8'h30 + k));
    end_xfer();
    rd1(8'h8F, d); check("R10 burst sets wp", d, 8'h80);
    wr1(8'h82, 8'h77); rd1(8'h83, d);
    check("R7 write blocked after burst", d, 8'h31);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule